// File: doc/BRIEF.md
# Compressed Instruction Expander

This block is a purely combinational translator. It turns a 16-bit compressed instruction for a 64-bit integer core into the equivalent 32-bit base instruction word. It is meant to sit between the fetch aligner and the main decoder. That way the decoder only ever sees full-width encodings. The forms it covers are:

- In quadrant 0, the stack-pointer add that produces an address.
- In quadrant 1, immediate adds, load-immediate, the stack adjust, load-upper and the right shifts.
- In quadrant 2, the left shift, the three stack-relative loads, jump-register, jump-and-link-register, move, add and breakpoint.

Each compressed form scatters its immediate bits in its own order. The expander gathers them back into place and widens three-bit register fields to x8..x15. It also raises an illegal flag for the reserved encodings that must trap.

The input port is 32 bits wide. When the two low bits are `11` the word is already full-width, and it is forwarded untouched. When the valid strobe is low the outputs are quiet. Whenever the illegal flag is raised the output word is zero, so the next stage never acts on half-formed data.

Top module: `cx_expand`

## Requirements
- R1: While `valid_i` is 0, `inst_o` is 0 and `illegal_o` is 0 regardless of `inst_i`.
- R2: With `valid_i` high and `inst_i[1:0] == 2'b11`, `inst_o` equals `inst_i` and `illegal_o` is 0.
- R3: Whenever `illegal_o` is 1, `inst_o` is 0. Encodings outside the covered set are flagged illegal. These are quadrant 0 with funct3 (bits 15:13) other than 000, quadrant 1 with funct3 101..111, quadrant 1 funct3 100 with bits 11:10 equal to 10 or 11, and quadrant 2 with funct3 101..111.
- R4: Quadrant 0, funct3 000 expands to ADDI rd'=8+bits[4:2], rs1=x2. Its zero-extended immediate has bit 2 from instr bit 6, bit 3 from bit 5, bits 5:4 from bits 12:11 and bits 9:6 from bits 10:7. A zero immediate is illegal, and this includes the all-zero halfword.
- R5: Quadrant 1 funct3 000 is ADDI rd,rd,imm, funct3 001 is ADDIW rd,rd,imm and funct3 010 is ADDI rd,x0,imm. The immediate is {bit 12, bits 6:2} sign-extended from bit 12. ADDI is illegal when exactly one of rd==x0 or imm==0 holds. The other two forms are illegal when rd==x0.
- R6: Quadrant 1 funct3 011 with rd==x2 is ADDI x2,x2,imm. The immediate has bit 4 from instr bit 6, bit 5 from bit 2, bit 6 from bit 5, bits 8:7 from bits 4:3, and bit 12 as the sign from bit 9 up. A zero immediate is illegal.
- R7: Quadrant 1 funct3 011 with rd other than x2 is LUI rd with upper field {bit 12, bits 6:2} sign-extended to 20 bits. It is illegal when rd==x0 or the field is zero.
- R8: Quadrant 1 funct3 100 with bits 11:10 = 00 gives SRLI and with 01 gives SRAI, both on rd'=8+bits[9:7]. Quadrant 2 funct3 000 gives SLLI on rd=bits[11:7]. The shift amount is {bit 12, bits 6:2}, and a zero amount is illegal. SLLI to x0 is also illegal.
- R9: Quadrant 2 funct3 010 is LW rd,off(x2) with off bits 4:2 from instr bits 6:4, bit 5 from bit 12 and bits 7:6 from bits 3:2. funct3 011 is LD and funct3 001 is FLD, both with off bits 4:3 from bits 6:5, bit 5 from bit 12 and bits 8:6 from bits 4:2. LW and LD to x0 are illegal.
- R10: Quadrant 2 funct3 100 with bit 12 = 0 is handled in two ways. With rs2 (bits 6:2) equal to zero it gives JALR x0,0(rd), illegal when rd==x0. Otherwise it gives ADD rd,x0,rs2, illegal when rd==x0.
- R11: Quadrant 2 funct3 100 with bit 12 = 1 decodes on rd and rs2. When both are zero it gives EBREAK (32'h00100073). When only rs2 is zero it gives JALR x1,0(rd). When rs2 is nonzero it gives ADD rd,rd,rs2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| valid_i | input | 1 | Qualifies `inst_i`; outputs are zero while low |
| inst_i | input | 32 | Instruction word; compressed forms use bits 15:0 |
| inst_o | output | 32 | Expanded or forwarded 32-bit instruction, zero when illegal |
| illegal_o | output | 1 | Input is a reserved or unsupported compressed encoding |

## Verification
Every result of this block is due in the same cycle its input is applied, since no register lies between `inst_i` and the outputs. The bench changes the input just after a rising edge and compares both outputs at the following falling edge. Each vector therefore has half a period to settle and can never be read against a neighbour's stimulus. The same timing serves the directed table, the exhaustive sweep of every compressed halfword against an arithmetic reference model, and the valid-low checks.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned REG_W  = 5;

    localparam logic [6:0] OPC_IMM    = 7'h13;
    localparam logic [6:0] OPC_IMM32  = 7'h1B;
    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_LOADFP = 7'h07;
    localparam logic [6:0] OPC_JALR   = 7'h67;
    localparam logic [6:0] OPC_REG    = 7'h33;
    localparam logic [6:0] OPC_SYS    = 7'h73;

    localparam logic [REG_W-1:0] X_ZERO = 5'd0;
    localparam logic [REG_W-1:0] X_LINK = 5'd1;
    localparam logic [REG_W-1:0] X_SP   = 5'd2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              bad;
    } cx_res_t;

    // widen a 3-bit compressed register index into x8..x15
    function automatic logic [REG_W-1:0] creg(input logic [2:0] r);
        return {2'b01, r};
    endfunction

    function automatic logic [WORD_W-1:0] enc_i(input logic [11:0] imm,
                                                input logic [4:0]  rs1,
                                                input logic [2:0]  f3,
                                                input logic [4:0]  rd,
                                                input logic [6:0]  op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [WORD_W-1:0] enc_r(input logic [4:0] rs2,
                                                input logic [4:0] rs1,
                                                input logic [4:0] rd);
        return {7'b0, rs2, rs1, 3'b000, rd, OPC_REG};
    endfunction

    function automatic logic [WORD_W-1:0] enc_u(input logic [19:0] imm,
                                                input logic [4:0]  rd);
        return {imm, rd, OPC_LUI};
    endfunction

    function automatic cx_res_t res_ok(input logic [WORD_W-1:0] w);
        cx_res_t r;
        r.word = w;
        r.bad  = 1'b0;
        return r;
    endfunction

    function automatic cx_res_t res_bad();
        cx_res_t r;
        r.word = '0;
        r.bad  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cx_quad0.sv
module cx_quad0
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output cx_res_t     r
);
    logic [9:0] spoff;

    always_comb begin
        spoff = {c[10:7], c[12:11], c[5], c[6], 2'b00};
        r     = res_bad();
        if (c[15:13] == 3'b000 && spoff != '0)
            r = res_ok(enc_i({2'b00, spoff}, X_SP, 3'b000, creg(c[4:2]), OPC_IMM));
    end

    // legal result always targets x8..x15 from the stack pointer (R4)
    always_comb begin
        if (!r.bad)
            p_q0_regs_r4: assert (r.word[19:15] == X_SP && r.word[11:10] == 2'b01 &&
                                  r.word[6:0] == OPC_IMM)
                else $error("quadrant 0 register/opcode mismatch");
    end
endmodule

// File: rtl/cx_quad1.sv
module cx_quad1
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output cx_res_t     r
);
    logic [4:0]  rd;
    logic [4:0]  rdp;
    logic [5:0]  imm6;
    logic [11:0] simm;
    logic [9:0]  sp16;

    always_comb begin
        rd   = c[11:7];
        rdp  = creg(c[9:7]);
        imm6 = {c[12], c[6:2]};
        simm = {{6{c[12]}}, imm6};
        sp16 = {c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
        r    = res_bad();
        unique case (c[15:13])
            3'b000: if ((rd == X_ZERO) == (imm6 == '0))
                        r = res_ok(enc_i(simm, rd, 3'b000, rd, OPC_IMM));
            3'b001: if (rd != X_ZERO)
                        r = res_ok(enc_i(simm, rd, 3'b000, rd, OPC_IMM32));
            3'b010: if (rd != X_ZERO)
                        r = res_ok(enc_i(simm, X_ZERO, 3'b000, rd, OPC_IMM));
            3'b011: begin
                if (rd == X_SP) begin
                    if (sp16 != '0)
                        r = res_ok(enc_i({{2{c[12]}}, sp16}, X_SP, 3'b000, X_SP, OPC_IMM));
                end else if (rd != X_ZERO && imm6 != '0) begin
                    r = res_ok(enc_u({{14{c[12]}}, imm6}, rd));
                end
            end
            3'b100: begin
                if (imm6 != '0) begin
                    if (c[11:10] == 2'b00)
                        r = res_ok(enc_i({6'b000000, imm6}, rdp, 3'b101, rdp, OPC_IMM));
                    else if (c[11:10] == 2'b01)
                        r = res_ok(enc_i({6'b010000, imm6}, rdp, 3'b101, rdp, OPC_IMM));
                end
            end
            default: r = res_bad();
        endcase
    end

    // legal quadrant-1 results only use the immediate/upper opcodes (R5, R7)
    always_comb begin
        if (!r.bad)
            p_q1_opcode_r5: assert (r.word[6:0] == OPC_IMM || r.word[6:0] == OPC_IMM32 ||
                                    r.word[6:0] == OPC_LUI)
                else $error("quadrant 1 opcode out of set");
    end
endmodule

// File: rtl/cx_quad2.sv
module cx_quad2
    import cx_pkg::*;
(
    input  logic [15:2] c,
    output cx_res_t     r
);
    logic [4:0] rd;
    logic [4:0] rs2;
    logic [5:0] sh;
    logic [7:0] woff;
    logic [8:0] doff;

    always_comb begin
        rd   = c[11:7];
        rs2  = c[6:2];
        sh   = {c[12], c[6:2]};
        woff = {c[3:2], c[12], c[6:4], 2'b00};
        doff = {c[4:2], c[12], c[6:5], 3'b000};
        r    = res_bad();
        unique case (c[15:13])
            3'b000: if (sh != '0 && rd != X_ZERO)
                        r = res_ok(enc_i({6'b000000, sh}, rd, 3'b001, rd, OPC_IMM));
            3'b001: r = res_ok(enc_i({3'b000, doff}, X_SP, 3'b011, rd, OPC_LOADFP));
            3'b010: if (rd != X_ZERO)
                        r = res_ok(enc_i({4'b0000, woff}, X_SP, 3'b010, rd, OPC_LOAD));
            3'b011: if (rd != X_ZERO)
                        r = res_ok(enc_i({3'b000, doff}, X_SP, 3'b011, rd, OPC_LOAD));
            3'b100: begin
                if (!c[12]) begin
                    if (rd != X_ZERO)
                        r = (rs2 == X_ZERO) ? res_ok(enc_i(12'd0, rd, 3'b000, X_ZERO, OPC_JALR))
                                            : res_ok(enc_r(rs2, X_ZERO, rd));
                end else if (rs2 != X_ZERO) begin
                    r = res_ok(enc_r(rs2, rd, rd));
                end else if (rd == X_ZERO) begin
                    r = res_ok(enc_i(12'd1, X_ZERO, 3'b000, X_ZERO, OPC_SYS));
                end else begin
                    r = res_ok(enc_i(12'd0, rd, 3'b000, X_LINK, OPC_JALR));
                end
            end
            default: r = res_bad();
        endcase
    end

    // legal quadrant-2 results stay within the expected opcode set (R11)
    always_comb begin
        if (!r.bad)
            p_q2_opcode_r11: assert (r.word[6:0] == OPC_IMM  || r.word[6:0] == OPC_LOAD ||
                                     r.word[6:0] == OPC_LOADFP || r.word[6:0] == OPC_JALR ||
                                     r.word[6:0] == OPC_REG  || r.word[6:0] == OPC_SYS)
                else $error("quadrant 2 opcode out of set");
    end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
    import cx_pkg::*;
(
    input  logic              valid_i,
    input  logic [WORD_W-1:0] inst_i,
    output logic [WORD_W-1:0] inst_o,
    output logic              illegal_o
);
    localparam int unsigned NQ = 3;

    cx_res_t q_res [NQ];
    cx_res_t pick;

    cx_quad0 u_q0 (.c(inst_i[HALF_W-1:2]), .r(q_res[0]));
    cx_quad1 u_q1 (.c(inst_i[HALF_W-1:2]), .r(q_res[1]));
    cx_quad2 u_q2 (.c(inst_i[HALF_W-1:2]), .r(q_res[2]));

    always_comb begin
        unique case (inst_i[1:0])
            2'b00:   pick = q_res[0];
            2'b01:   pick = q_res[1];
            2'b10:   pick = q_res[2];
            default: pick = res_ok(inst_i);
        endcase
        if (!valid_i) begin
            inst_o    = '0;
            illegal_o = 1'b0;
        end else begin
            inst_o    = pick.bad ? '0 : pick.word;
            illegal_o = pick.bad;
        end
    end

    always_comb begin
        if (!valid_i)
            p_idle_quiet_r1: assert (inst_o == '0 && !illegal_o)
                else $error("outputs active while not valid");
        if (valid_i && inst_i[1:0] == 2'b11)
            p_full_width_r2: assert (inst_o == inst_i && !illegal_o)
                else $error("full-width word altered");
        if (valid_i && inst_i[HALF_W-1:0] == '0)
            p_zero_half_r4: assert (illegal_o)
                else $error("all-zero halfword accepted");
    end
endmodule

// File: tb/cx_expand_tb.sv
module cx_expand_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i;
    logic [31:0] inst_i;
    logic [31:0] inst_o;
    logic        illegal_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cx_expand u_dut (.valid_i(valid_i), .inst_i(inst_i), .inst_o(inst_o), .illegal_o(illegal_o));

    // {illegal, input, expected word}, tag in TAGS
    localparam int NV = 16;
    localparam logic [64:0] TV [NV] = '{
        {1'b0, 32'h0000_0085, 32'h0010_8093},   // R5 addi x1,1
        {1'b0, 32'h0000_10FD, 32'hFFF0_8093},   // R5 addi x1,-1
        {1'b1, 32'h0000_4005, 32'h0000_0000},   // R5 li x0
        {1'b0, 32'h0000_9002, 32'h0010_0073},   // R11 ebreak
        {1'b0, 32'h0000_9082, 32'h0000_80E7},   // R11 jalr x1
        {1'b0, 32'h0000_8082, 32'h0000_8067},   // R10 jr x1
        {1'b0, 32'h0000_852E, 32'h00B0_0533},   // R10 mv x10,x11
        {1'b1, 32'h0000_0000, 32'h0000_0000},   // R4 all-zero
        {1'b0, 32'h0000_0040, 32'h0041_0413},   // R4 addi4spn x8,4
        {1'b0, 32'h0010_8093, 32'h0010_8093},   // R2 pass-through
        {1'b1, 32'h0000_0082, 32'h0000_0000},   // R8 slli zero amount
        {1'b0, 32'h0000_8005, 32'h0014_5413},   // R8 srli x8,1
        {1'b1, 32'h0000_6101, 32'h0000_0000},   // R6 addi16sp zero
        {1'b0, 32'h0000_6085, 32'h0000_10B7},   // R7 lui x1,1
        {1'b0, 32'h0000_4092, 32'h0041_2083},   // R9 lwsp x1,4
        {1'b1, 32'h0000_A001, 32'h0000_0000}    // R3 unsupported jump
    };
    localparam int TAGS [NV] = '{5, 5, 5, 11, 11, 10, 10, 4, 4, 2, 8, 8, 6, 7, 9, 3};

    function automatic logic [31:0] it(int imm, int rs1, int f3, int rd, int op);
        int v;
        v = ((imm & 'hFFF) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
        return v;
    endfunction

    function automatic logic [31:0] rt(int rs2, int rs1, int rd);
        int v;
        v = (rs2 << 20) | (rs1 << 15) | (rd << 7) | 'h33;
        return v;
    endfunction

    // arithmetic reference model, returns {illegal, word}
    function automatic logic [32:0] ref_x(input logic [15:0] c);
        int rd, rs2, rp, si, sh, u;
        logic [31:0] w;
        logic bad;
        rd  = int'(c[11:7]);
        rs2 = int'(c[6:2]);
        rp  = 8 + int'(c[9:7]);
        si  = c[12] ? int'(c[6:2]) - 32 : int'(c[6:2]);
        sh  = int'(c[12]) * 32 + int'(c[6:2]);
        w = 0;
        bad = 1'b0;
        case ({c[1:0], c[15:13]})
            5'b00_000: begin
                u = int'(c[6]) * 4 + int'(c[5]) * 8 + int'(c[12:11]) * 16 + int'(c[10:7]) * 64;
                bad = (u == 0);
                w = it(u, 2, 0, 8 + int'(c[4:2]), 'h13);
            end
            5'b01_000: begin bad = ((rd == 0) != (si == 0)); w = it(si, rd, 0, rd, 'h13); end
            5'b01_001: begin bad = (rd == 0); w = it(si, rd, 0, rd, 'h1B); end
            5'b01_010: begin bad = (rd == 0); w = it(si, 0, 0, rd, 'h13); end
            5'b01_011: begin
                if (rd == 2) begin
                    u = int'(c[6]) * 16 + int'(c[2]) * 32 + int'(c[5]) * 64 + int'(c[4:3]) * 128
                        - (c[12] ? 512 : 0);
                    bad = (u == 0);
                    w = it(u, 2, 0, 2, 'h13);
                end else begin
                    bad = (rd == 0) || (si == 0);
                    w = ((si & 'hFFFFF) << 12) | (rd << 7) | 'h37;
                end
            end
            5'b01_100: begin
                bad = (sh == 0) || c[11];
                w = it(sh + (c[10] ? 'h400 : 0), rp, 5, rp, 'h13);
            end
            5'b10_000: begin bad = (sh == 0) || (rd == 0); w = it(sh, rd, 1, rd, 'h13); end
            5'b10_001: begin
                u = int'(c[6:5]) * 8 + int'(c[12]) * 32 + int'(c[4:2]) * 64;
                w = it(u, 2, 3, rd, 'h07);
            end
            5'b10_010: begin
                u = int'(c[6:4]) * 4 + int'(c[12]) * 32 + int'(c[3:2]) * 64;
                bad = (rd == 0);
                w = it(u, 2, 2, rd, 'h03);
            end
            5'b10_011: begin
                u = int'(c[6:5]) * 8 + int'(c[12]) * 32 + int'(c[4:2]) * 64;
                bad = (rd == 0);
                w = it(u, 2, 3, rd, 'h03);
            end
            5'b10_100: begin
                if (!c[12]) begin
                    bad = (rd == 0);
                    w = (rs2 == 0) ? it(0, rd, 0, 0, 'h67) : rt(rs2, 0, rd);
                end else if (rs2 != 0) begin
                    w = rt(rs2, rd, rd);
                end else if (rd == 0) begin
                    w = 32'h0010_0073;
                end else begin
                    w = it(0, rd, 0, 1, 'h67);
                end
            end
            default: bad = 1'b1;
        endcase
        if (bad) w = 0;
        return {bad, w};
    endfunction

    task automatic chk(input string tag, input logic v, input logic [31:0] x,
                       input logic [31:0] ew, input logic eb);
        @(posedge clk);
        #1;
        valid_i = v;
        inst_i  = x;
        @(negedge clk);
        checks++;
        if (inst_o !== ew || illegal_o !== eb) begin
            errors++;
            $display("FAIL %s in=%h: got word=%h ill=%b, expected word=%h ill=%b",
                     tag, x, inst_o, illegal_o, ew, eb);
        end
    endtask

    initial begin
        logic [32:0] e;
        valid_i = 1'b0;
        inst_i  = 32'h0000_0085;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 quiet outputs during reset
        if (inst_o !== 32'h0 || illegal_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got word=%h ill=%b, expected word=00000000 ill=0",
                     inst_o, illegal_o);
        end
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            chk($sformatf("R%0d vector %0d", TAGS[i], i), 1'b1, TV[i][63:32], TV[i][31:0], TV[i][64]);

        // R1: valid low hides both a legal form and an illegal one
        chk("R1 idle legal", 1'b0, 32'h0000_0085, 32'h0, 1'b0);
        chk("R1 idle zero", 1'b0, 32'h0000_0000, 32'h0, 1'b0);
        chk("R1 idle full", 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b0);
        // R2: full-width word with arbitrary upper bits
        chk("R2 full", 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);
        // R3: illegal with nonzero upper bits still gives a zero word
        chk("R3 upper bits", 1'b1, 32'hFFFF_0000, 32'h0, 1'b1);

        // R3..R11 exhaustive sweep of compressed halfwords
        for (int i = 0; i < 65536; i++) begin
            if (i[1:0] != 2'b11) begin
                e = ref_x(i[15:0]);
                chk("R3-R11 sweep", 1'b1, {16'h0, i[15:0]}, e[31:0], e[32]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule